// File: doc/BRIEF.md
# Iterative Cipher Round Sequencer

This block drives a block cipher of the add-rotate-xor family one round at a time. It does no arithmetic itself. It holds the two data words, the current round key and a queue of three pending key-schedule words. For every round it launches two external multi-cycle engines together: a round engine that mixes the data words with the current round key, and a key engine that derives the next round key and the next schedule word. The block waits for both engines to report completion, in either order and after any latency, before it moves to the next round.

A host loads a plaintext and a 128-bit key with a single start pulse. When the configured number of rounds has run, the sequencer latches the ciphertext and raises done. Done stays high until the next accepted start. A start pulse that arrives while a run is in progress is ignored. A one-hot start trace shows which round is being launched, for debug.

Top module: `round_seq`

## Requirements
- R1: After reset, done_o, ct_o, rnd_start_o, key_start_o and start_vec_o are all zero.
- R2: key_i is split as {l2, l1, l0, k0}, from the most significant word down. At the launch of round 1, rnd_key_o and key_k_o carry k0, key_l_o carries l0, key_idx_o is 0, and rnd_x_o/rnd_y_o carry pt_i[2W-1:W]/pt_i[W-1:0].
- R3: Each round launches both engines with a single-cycle pulse on rnd_start_o and key_start_o. All operand outputs stay stable from the launch cycle until that round commits.
- R4: A round commits only after both rnd_fin_i and key_fin_i have been seen for it, whatever their order or latency. The next launch never happens while either engine is still working.
- R5: After each key step the schedule queue drops its oldest word and appends key_l_i, so round i+1 presents l(i+1) on key_l_o.
- R6: Round i+1 presents the round engine's results (rnd_x_i, rnd_y_i) on rnd_x_o/rnd_y_o and the key engine's key_k_i as the round key.
- R7: start_vec_o is all zero except in a launch cycle, where only bit r-1 is set for round r.
- R8: When the last round commits, done_o rises and ct_o becomes {rnd_x_i, rnd_y_i} from that round. At no other time does ct_o change.
- R9: start_i is ignored while a run is in progress.
- R10: done_o stays high until a start is accepted and drops in the cycle after it.
- R11: ROUNDS is a parameter from 1 to 27. key_idx_o counts 0 to ROUNDS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load plaintext and key and begin a run (when idle) |
| pt_i | input | 2*WORD_W | Plaintext {x, y} |
| key_i | input | 4*WORD_W | Key {l2, l1, l0, k0} |
| done_o | output | 1 | Ciphertext valid; held until next start |
| ct_o | output | 2*WORD_W | Ciphertext {x, y} |
| rnd_start_o | output | 1 | Launch pulse to the round engine |
| rnd_x_o | output | WORD_W | Round engine x operand |
| rnd_y_o | output | WORD_W | Round engine y operand |
| rnd_key_o | output | WORD_W | Round key for the current round |
| rnd_fin_i | input | 1 | Round engine completion pulse |
| rnd_x_i | input | WORD_W | Round engine x result |
| rnd_y_i | input | WORD_W | Round engine y result |
| key_start_o | output | 1 | Launch pulse to the key engine |
| key_k_o | output | WORD_W | Current round key to the key engine |
| key_l_o | output | WORD_W | Oldest pending schedule word |
| key_idx_o | output | IDX_W | Round index, starting at 0 |
| key_fin_i | input | 1 | Key engine completion pulse |
| key_k_i | input | WORD_W | Next round key |
| key_l_i | input | WORD_W | New schedule word |
| start_vec_o | output | ROUNDS | One-hot launch trace |

## Verification
The bench builds two copies with 32-bit words, one with ROUNDS=3 and one with ROUNDS=27. The short build is swept over every pairing of round-engine and key-engine latencies from 0 to 3 extra cycles, so that every finish order and every overlap of the two completions is reached. At every launch the bench checks each round's operands and trace bit against its own arithmetic model. The 27-round build reaches the upper parameter limit, a five-bit round index and the full schedule queue rotation. Its ciphertext is checked against a published 27-round test vector.

// File: rtl/round_seq_pkg.sv
package round_seq_pkg;
    // upper bound on the configurable round count
    localparam int MAX_ROUNDS = 27;
    // number of pending schedule words held between rounds
    localparam int L_WORDS    = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/round_seq_lqueue.sv
// Shift queue of pending key-schedule words; entry 0 is the oldest.
module round_seq_lqueue #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [DEPTH*WORD_W-1:0]  load_words_i,
    input  logic                     shift_i,
    input  logic [WORD_W-1:0]        push_i,
    output logic [WORD_W-1:0]        head_o
);
    logic [DEPTH-1:0][WORD_W-1:0] q_d, q_q;

    for (genvar j = 0; j < DEPTH; j++) begin : g_entry
        if (j == DEPTH - 1) begin : g_tail
            assign q_d[j] = load_i  ? load_words_i[j*WORD_W +: WORD_W] :
                            shift_i ? push_i : q_q[j];
        end else begin : g_body
            assign q_d[j] = load_i  ? load_words_i[j*WORD_W +: WORD_W] :
                            shift_i ? q_q[j+1] : q_q[j];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_o = q_q[0];
endmodule

// File: rtl/round_seq_hshake.sv
// Tracks one engine: armed at launch, captures its result on the first
// completion pulse while armed, and holds it until the round commits.
module round_seq_hshake #(
    parameter int RES_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             launch_i,
    input  logic             fin_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             clear_i,
    output logic             got_o,
    output logic [RES_W-1:0] res_o
);
    typedef struct packed {
        logic             pend;
        logic             got;
        logic [RES_W-1:0] res;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (clear_i) begin
            hs_d.got = 1'b0;
        end
        if (launch_i) begin
            hs_d.pend = 1'b1;
            hs_d.got  = 1'b0;
        end else if (fin_i && hs_q.pend) begin
            hs_d.pend = 1'b0;
            hs_d.got  = 1'b1;
            hs_d.res  = res_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign got_o = hs_q.got;
    assign res_o = hs_q.res;
endmodule

// File: rtl/round_seq_trace.sv
// One-hot decode of the round being launched.
module round_seq_trace #(
    parameter int ROUNDS = 3,
    parameter int IDX_W  = 2
) (
    input  logic              active_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ROUNDS-1:0] vec_o
);
    for (genvar r = 0; r < ROUNDS; r++) begin : g_bit
        assign vec_o[r] = active_i && (idx_i == IDX_W'(r));
    end
endmodule

// File: rtl/round_seq.sv
module round_seq
    import round_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ROUNDS = 3,
    parameter int IDX_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [2*WORD_W-1:0] pt_i,
    input  logic [4*WORD_W-1:0] key_i,
    output logic                done_o,
    output logic [2*WORD_W-1:0] ct_o,
    output logic                rnd_start_o,
    output logic [WORD_W-1:0]   rnd_x_o,
    output logic [WORD_W-1:0]   rnd_y_o,
    output logic [WORD_W-1:0]   rnd_key_o,
    input  logic                rnd_fin_i,
    input  logic [WORD_W-1:0]   rnd_x_i,
    input  logic [WORD_W-1:0]   rnd_y_i,
    output logic                key_start_o,
    output logic [WORD_W-1:0]   key_k_o,
    output logic [WORD_W-1:0]   key_l_o,
    output logic [IDX_W-1:0]    key_idx_o,
    input  logic                key_fin_i,
    input  logic [WORD_W-1:0]   key_k_i,
    input  logic [WORD_W-1:0]   key_l_i,
    output logic [ROUNDS-1:0]   start_vec_o
);
    localparam int BLK_W = 2 * WORD_W;
    localparam int LQ_W  = L_WORDS * WORD_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS - 1);

    if (ROUNDS < 1 || ROUNDS > MAX_ROUNDS) begin : g_bad_rounds
        $error("round_seq: ROUNDS out of range");
    end

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] k;
        logic [BLK_W-1:0]  ct;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             launch;
    logic             commit;
    logic             q_load;
    logic             r_got, k_got;
    logic [BLK_W-1:0] r_res, k_res;
    logic [WORD_W-1:0] l_head;

    // round engine result {x, y}
    round_seq_hshake #(.RES_W(BLK_W)) i_rnd_hs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .launch_i(launch),
        .fin_i   (rnd_fin_i),
        .res_i   ({rnd_x_i, rnd_y_i}),
        .clear_i (commit),
        .got_o   (r_got),
        .res_o   (r_res)
    );

    // key engine result {next key, new schedule word}
    round_seq_hshake #(.RES_W(BLK_W)) i_key_hs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .launch_i(launch),
        .fin_i   (key_fin_i),
        .res_i   ({key_k_i, key_l_i}),
        .clear_i (commit),
        .got_o   (k_got),
        .res_o   (k_res)
    );

    round_seq_lqueue #(.WORD_W(WORD_W), .DEPTH(L_WORDS)) i_lq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (q_load),
        .load_words_i(key_i[WORD_W +: LQ_W]),
        .shift_i     (commit),
        .push_i      (k_res[WORD_W-1:0]),
        .head_o      (l_head)
    );

    round_seq_trace #(.ROUNDS(ROUNDS), .IDX_W(IDX_W)) i_trace (
        .active_i(launch),
        .idx_i   (ctl_q.idx),
        .vec_o   (start_vec_o)
    );

    always_comb begin
        ctl_d  = ctl_q;
        launch = 1'b0;
        commit = 1'b0;
        q_load = 1'b0;
        unique case (ctl_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    q_load     = 1'b1;
                    ctl_d.st   = SEQ_LAUNCH;
                    ctl_d.idx  = '0;
                    ctl_d.x    = pt_i[BLK_W-1:WORD_W];
                    ctl_d.y    = pt_i[WORD_W-1:0];
                    ctl_d.k    = key_i[WORD_W-1:0];
                    ctl_d.done = 1'b0;
                end
            end
            SEQ_LAUNCH: begin
                launch   = 1'b1;
                ctl_d.st = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (r_got && k_got) begin
                    commit  = 1'b1;
                    ctl_d.x = r_res[BLK_W-1:WORD_W];
                    ctl_d.y = r_res[WORD_W-1:0];
                    ctl_d.k = k_res[BLK_W-1:WORD_W];
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.st   = SEQ_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.ct   = r_res;
                    end else begin
                        ctl_d.st  = SEQ_LAUNCH;
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q    <= '0;
            ctl_q.st <= SEQ_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rnd_start_o = launch;
    assign key_start_o = launch;
    assign rnd_x_o     = ctl_q.x;
    assign rnd_y_o     = ctl_q.y;
    assign rnd_key_o   = ctl_q.k;
    assign key_k_o     = ctl_q.k;
    assign key_l_o     = l_head;
    assign key_idx_o   = ctl_q.idx;
    assign done_o      = ctl_q.done;
    assign ct_o        = ctl_q.ct;
endmodule

// File: rtl/round_seq_chk.sv
module round_seq_chk #(
    parameter int WORD_W = 32,
    parameter int ROUNDS = 3,
    parameter int IDX_W  = 2
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic                done_o,
    input logic [2*WORD_W-1:0] ct_o,
    input logic                rnd_start_o,
    input logic [WORD_W-1:0]   rnd_x_o,
    input logic [WORD_W-1:0]   rnd_key_o,
    input logic [WORD_W-1:0]   key_l_o,
    input logic [IDX_W-1:0]    key_idx_o,
    input logic [ROUNDS-1:0]   start_vec_o
);
    AST_VEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(start_vec_o));                                        // R7
    AST_VEC_ON_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_start_o |-> $countones(start_vec_o) == 1);                 // R7
    AST_VEC_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rnd_start_o |-> start_vec_o == '0);                           // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_start_o |=> !rnd_start_o);                                 // R3
    AST_OPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_start_o |=> $stable(rnd_x_o) && $stable(rnd_key_o) && $stable(key_l_o)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !start_i |=> done_o);                                // R10
    AST_CT_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$rose(done_o) |-> $stable(ct_o));                             // R8
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_start_o |-> !done_o);                                      // R9
    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(key_idx_o) < ROUNDS);                                     // R11
endmodule

bind round_seq round_seq_chk #(
    .WORD_W(WORD_W),
    .ROUNDS(ROUNDS),
    .IDX_W (IDX_W)
) i_chk (.*);

// File: tb/test_round_seq.sv
`timescale 1ns/1ps

// Behavioural engines with programmable latency (extra cycles after launch).
module test_round_seq_engines #(
    parameter int W  = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rnd_start,
    input  logic [W-1:0]  rx,
    input  logic [W-1:0]  ry,
    input  logic [W-1:0]  rk,
    input  logic          key_start,
    input  logic [W-1:0]  kk,
    input  logic [W-1:0]  kl,
    input  logic [IW-1:0] kidx,
    input  int            lat_r,
    input  int            lat_k,
    output logic          rnd_fin,
    output logic [W-1:0]  ox,
    output logic [W-1:0]  oy,
    output logic          busy_r,
    output logic          key_fin,
    output logic [W-1:0]  ok,
    output logic [W-1:0]  ol,
    output logic          busy_k
);
    int cr = 0, ck = 0;
    logic [W-1:0] nx, ny, nl, nk;

    initial begin
        rnd_fin = 0; key_fin = 0; busy_r = 0; busy_k = 0;
        ox = '0; oy = '0; ok = '0; ol = '0;
    end

    always @(posedge clk) begin
        rnd_fin <= 1'b0;
        if (rnd_start) begin
            nx = ({rx[7:0], rx[W-1:8]} + ry) ^ rk;
            ny = {ry[W-4:0], ry[W-1:W-3]} ^ nx;
            ox <= nx; oy <= ny;
            busy_r <= 1'b1; cr <= lat_r;
        end else if (busy_r) begin
            if (cr == 0) begin rnd_fin <= 1'b1; busy_r <= 1'b0; end
            else cr <= cr - 1;
        end
    end

    always @(posedge clk) begin
        key_fin <= 1'b0;
        if (key_start) begin
            nl = (kk + {kl[7:0], kl[W-1:8]}) ^ W'(kidx);
            nk = {kk[W-4:0], kk[W-1:W-3]} ^ nl;
            ol <= nl; ok <= nk;
            busy_k <= 1'b1; ck <= lat_k;
        end else if (busy_k) begin
            if (ck == 0) begin key_fin <= 1'b1; busy_k <= 1'b0; end
            else ck <= ck - 1;
        end
    end
endmodule

module test_round_seq;
    localparam int W  = 32;
    localparam int RA = 3;
    localparam int RB = 27;
    localparam int IA = 2;
    localparam int IB = 5;

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int lr       = 0;
    bit ended    = 0;

    // ---------------- DUT A (3 rounds) ----------------
    logic start_a = 0;
    logic [2*W-1:0] pt_a = '0;
    logic [4*W-1:0] key_a = '0;
    logic done_a, rs_a, ks_a, rf_a, kf_a, br_a, bk_a;
    logic [2*W-1:0] ct_a;
    logic [W-1:0] rx_a, ry_a, rk_a, kk_a, kl_a, xi_a, yi_a, ki_a, li_a;
    logic [IA-1:0] idx_a;
    logic [RA-1:0] vec_a;
    int lat_r_a = 0, lat_k_a = 0;

    round_seq #(.WORD_W(W), .ROUNDS(RA)) i_round_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .pt_i(pt_a), .key_i(key_a),
        .done_o(done_a), .ct_o(ct_a),
        .rnd_start_o(rs_a), .rnd_x_o(rx_a), .rnd_y_o(ry_a), .rnd_key_o(rk_a),
        .rnd_fin_i(rf_a), .rnd_x_i(xi_a), .rnd_y_i(yi_a),
        .key_start_o(ks_a), .key_k_o(kk_a), .key_l_o(kl_a), .key_idx_o(idx_a),
        .key_fin_i(kf_a), .key_k_i(ki_a), .key_l_i(li_a), .start_vec_o(vec_a)
    );
    test_round_seq_engines #(.W(W), .IW(IA)) i_eng_a (
        .clk(clk), .rnd_start(rs_a), .rx(rx_a), .ry(ry_a), .rk(rk_a),
        .key_start(ks_a), .kk(kk_a), .kl(kl_a), .kidx(idx_a),
        .lat_r(lat_r_a), .lat_k(lat_k_a),
        .rnd_fin(rf_a), .ox(xi_a), .oy(yi_a), .busy_r(br_a),
        .key_fin(kf_a), .ok(ki_a), .ol(li_a), .busy_k(bk_a)
    );

    // ---------------- DUT B (27 rounds) ----------------
    logic start_b = 0;
    logic [2*W-1:0] pt_b = '0;
    logic [4*W-1:0] key_b = '0;
    logic done_b, rs_b, ks_b, rf_b, kf_b, br_b, bk_b;
    logic [2*W-1:0] ct_b;
    logic [W-1:0] rx_b, ry_b, rk_b, kk_b, kl_b, xi_b, yi_b, ki_b, li_b;
    logic [IB-1:0] idx_b;
    logic [RB-1:0] vec_b;
    int lat_r_b = 0, lat_k_b = 0;

    round_seq #(.WORD_W(W), .ROUNDS(RB)) i_round_seq_long (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .pt_i(pt_b), .key_i(key_b),
        .done_o(done_b), .ct_o(ct_b),
        .rnd_start_o(rs_b), .rnd_x_o(rx_b), .rnd_y_o(ry_b), .rnd_key_o(rk_b),
        .rnd_fin_i(rf_b), .rnd_x_i(xi_b), .rnd_y_i(yi_b),
        .key_start_o(ks_b), .key_k_o(kk_b), .key_l_o(kl_b), .key_idx_o(idx_b),
        .key_fin_i(kf_b), .key_k_i(ki_b), .key_l_i(li_b), .start_vec_o(vec_b)
    );
    test_round_seq_engines #(.W(W), .IW(IB)) i_eng_b (
        .clk(clk), .rnd_start(rs_b), .rx(rx_b), .ry(ry_b), .rk(rk_b),
        .key_start(ks_b), .kk(kk_b), .kl(kl_b), .kidx(idx_b),
        .lat_r(lat_r_b), .lat_k(lat_k_b),
        .rnd_fin(rf_b), .ox(xi_b), .oy(yi_b), .busy_r(br_b),
        .key_fin(kf_b), .ok(ki_b), .ol(li_b), .busy_k(bk_b)
    );

    // ---------------- golden model ----------------
    logic [W-1:0] ex [0:RB-1];
    logic [W-1:0] ey [0:RB-1];
    logic [W-1:0] ek [0:RB-1];
    logic [W-1:0] el [0:RB-1];

    function automatic logic [W-1:0] ror8(input logic [W-1:0] v);
        return {v[7:0], v[W-1:8]};
    endfunction
    function automatic logic [W-1:0] rol3(input logic [W-1:0] v);
        return {v[W-4:0], v[W-1:W-3]};
    endfunction

    task automatic golden(input logic [2*W-1:0] pt, input logic [4*W-1:0] key,
                          input int n, output logic [2*W-1:0] ct);
        logic [W-1:0] x, y, k, ln;
        logic [W-1:0] l [0:RB+2];
        x = pt[2*W-1:W]; y = pt[W-1:0];
        k = key[W-1:0];
        l[0] = key[2*W-1:W]; l[1] = key[3*W-1:2*W]; l[2] = key[4*W-1:3*W];
        for (int i = 0; i < n; i++) begin
            ex[i] = x; ey[i] = y; ek[i] = k; el[i] = l[i];
            x = (ror8(x) + y) ^ k;
            y = rol3(y) ^ x;
            ln = (k + ror8(l[i])) ^ W'(i);
            k = rol3(k) ^ ln;
            l[i+3] = ln;
        end
        ct = {x, y};
    endtask

    task automatic chk(input bit good, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!good) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- launch monitor for DUT A ----------------
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (rs_a) begin
                chk(lr < RA, "R4 launch count within run", 128'(lr), 128'(RA));
                if (lr < RA) begin
                    chk(vec_a == RA'(1 << lr), "R7 trace bit at launch", 128'(vec_a), 128'(1 << lr));
                    chk(ks_a, "R3 key engine launched with round engine", 128'(ks_a), 128'(1));
                    chk(!br_a && !bk_a, "R4 both engines idle at launch", 128'({br_a, bk_a}), 128'(0));
                    chk(rx_a == ex[lr] && ry_a == ey[lr], lr == 0 ? "R2 plaintext words" : "R6 data words",
                        128'({rx_a, ry_a}), 128'({ex[lr], ey[lr]}));
                    chk(rk_a == ek[lr] && kk_a == ek[lr], lr == 0 ? "R2 first round key k0" : "R6 round key",
                        128'({rk_a, kk_a}), 128'({ek[lr], ek[lr]}));
                    chk(kl_a == el[lr], lr == 0 ? "R2 first schedule word l0" : "R5 schedule queue word",
                        128'(kl_a), 128'(el[lr]));
                    chk(int'(idx_a) == lr, "R11 round index", 128'(idx_a), 128'(lr));
                end
                lr++;
            end else if (vec_a != '0) begin
                chk(1'b0, "R7 trace zero outside launch", 128'(vec_a), 128'(0));
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic run_a(input logic [2*W-1:0] pt, input logic [4*W-1:0] key,
                         input int lrl, input int lkl, input bit poke);
        logic [2*W-1:0] exp_ct, ct_before;
        int t;
        lat_r_a = lrl; lat_k_a = lkl;
        golden(pt, key, RA, exp_ct);
        lr = 0;
        ct_before = ct_a;
        @(negedge clk);
        pt_a = pt; key_a = key; start_a = 1;
        @(negedge clk);
        start_a = 0;
        chk(!done_a, "R10 done drops after accepted start", 128'(done_a), 128'(0));
        chk(ct_a == ct_before, "R8 ct unchanged while running", 128'(ct_a), 128'(ct_before));
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            pt_a = ~pt; key_a = ~key; start_a = 1;
            @(negedge clk);
            start_a = 0;
        end
        t = 0;
        while (!done_a && t < 1000) begin @(negedge clk); t++; end
        chk(done_a, "R8 done after final round", 128'(done_a), 128'(1));
        chk(ct_a == exp_ct, poke ? "R9 busy start ignored, ciphertext" : "R8 ciphertext",
            128'(ct_a), 128'(exp_ct));
        chk(lr == RA, "R4 all rounds launched once", 128'(lr), 128'(RA));
        repeat (4) @(negedge clk);
        chk(done_a, "R10 done held while idle", 128'(done_a), 128'(1));
        chk(ct_a == exp_ct, "R8 ct held after done", 128'(ct_a), 128'(exp_ct));
    endtask

    task automatic run_b(input logic [2*W-1:0] pt, input logic [4*W-1:0] key,
                         input int lrl, input int lkl, input logic [2*W-1:0] known, input bit use_known);
        logic [2*W-1:0] exp_ct;
        int t;
        int launches;
        lat_r_b = lrl; lat_k_b = lkl;
        golden(pt, key, RB, exp_ct);
        if (use_known)
            chk(exp_ct == known, "R11 bench model matches 27-round vector", 128'(exp_ct), 128'(known));
        @(negedge clk);
        pt_b = pt; key_b = key; start_b = 1;
        @(negedge clk);
        start_b = 0;
        t = 0; launches = (rs_b) ? 1 : 0;
        while (!done_b && t < 5000) begin
            @(negedge clk); t++;
            if (rs_b) begin
                chk(vec_b == RB'(1) << launches, "R7 trace bit, 27 rounds", 128'(vec_b), 128'(1) << launches);
                launches++;
            end
        end
        chk(done_b, "R11 done after 27 rounds", 128'(done_b), 128'(1));
        chk(launches == RB, "R11 launch count 27", 128'(launches), 128'(RB));
        chk(ct_b == (use_known ? known : exp_ct), "R11 27-round ciphertext", 128'(ct_b),
            128'(use_known ? known : exp_ct));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_a && ct_a == '0 && !rs_a && !ks_a && vec_a == '0, "R1 reset state A",
            128'({done_a, rs_a, ks_a, vec_a}), 128'(0));
        chk(!done_b && ct_b == '0 && !rs_b && vec_b == '0, "R1 reset state B",
            128'({done_b, rs_b, vec_b}), 128'(0));
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!done_a && ct_a == '0 && vec_a == '0, "R1 state after reset release",
            128'({done_a, vec_a}), 128'(0));

        for (int lrl = 0; lrl < 4; lrl++) begin
            for (int lkl = 0; lkl < 4; lkl++) begin
                int n;
                logic [2*W-1:0] pt;
                logic [4*W-1:0] key;
                n = lrl * 4 + lkl;
                pt  = {32'h9E3779B9 * (n + 1), 32'h7F4A7C15 ^ W'(n * 77)};
                key = {32'hA5A5_0000 + W'(n), 32'h0F1E2D3C * (n + 3),
                       32'h1234_5678 ^ W'(n << 8), 32'hC001_D00D + W'(n * 3)};
                run_a(pt, key, lrl, lkl, n[0]);
            end
        end

        run_b(64'h3b726574_7475432d, 128'h1b1a1918_13121110_0b0a0908_03020100,
              0, 1, 64'h8c6fa548_454e028b, 1'b1);
        run_b(64'h0123_4567_89ab_cdef, 128'hfedc_ba98_7654_3210_0f0e_0d0c_0b0a_0908,
              2, 0, 64'h0, 1'b0);

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule